// File: doc/BRIEF.md
# Dual-Read Bandwidth Stall Controller

This block tracks instructions as tokens moving through a five-stage in-order pipeline. The stages are decode, address, memory, execute and write-back. Each token records four things: how many memory reads it makes (0, 1 or 2), which RAM region each read targets, whether it writes back, and where that write lands. The local RAM has two ports. Its two-port region can serve two accesses in one cycle, and a write retiring from write-back counts against that budget.

A hazard unit watches two stages. The first is the memory stage, which may hold a dual-read instruction. The second is the write-back stage, which may hold a pending write. The budget is overrun when both reads and the write all go to the two-port region. In that case the controller freezes decode, address and memory for one cycle, puts an empty slot into execute, and lets the older instruction in execute retire to write-back. The stall is never longer than one cycle, because the conflicting write has left by the next cycle. A free-running cycle counter and a stall counter make the timing observable.

A small state machine makes the stall decision. Its states are `ST_RUN`, where a detected conflict raises the stall and the next state is `ST_HOLD`, and `ST_HOLD`, the cycle in which the inserted empty slot sits in execute. `ST_HOLD` never stalls and always returns to `ST_RUN`.

Top module: `dualrd_stall_top`

## Requirements
- R1: A synchronous active-high reset clears every stage valid bit, deasserts `stall` and `bubble`, and zeroes both counters.
- R2: With no stall, a token accepted at a clock edge appears in decode (stage index 0) after that edge and moves up one stage index per edge, through address (1), memory (2) and execute (3) to write-back (4). Each stage reports its valid bit and tag.
- R3: `stall` is high in a cycle exactly when the memory stage holds a valid token with read count 2 and both read-region flags set (1 = two-port region), and the write-back stage holds a valid token with write enable 1 and write-region flag 1, and the controller is in `ST_RUN`.
- R4: If either read-region flag of the dual-read token is 0 (single-port region), no stall occurs and the token leaves memory after one cycle.
- R5: A write-back token with write-region flag 0, or with write enable 0 (a register write), causes no stall.
- R6: In a stall cycle, decode, address and memory keep their contents. Execute is loaded with an invalid slot, and write-back takes the previous execute token.
- R7: A stall lasts at most one cycle. The cycle after a stall never stalls, even if the new write-back token is also a two-port write.
- R8: An invalid slot in write-back never counts as a pending write.
- R9: A token with a read count below 2 never causes a stall, whatever its region flags are.
- R10: `issue_rdy` equals the inverse of `stall`. An issued token presented during a stall cycle is not captured.
- R11: `cycle_cnt` increments by one on every edge out of reset. `stall_cnt` increments by one for each stall cycle.
- R12: `bubble` is high exactly in the cycle that follows a stall cycle, while the inserted slot occupies execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Token presented for issue into decode |
| in_tag | input | TAG_W | Identifier carried by the token |
| in_nrd | input | 2 | Number of memory reads (0..2) |
| in_rd0_dp | input | 1 | First read targets the two-port region |
| in_rd1_dp | input | 1 | Second read targets the two-port region |
| in_wb_en | input | 1 | Token writes back to RAM |
| in_wb_dp | input | 1 | Write-back targets the two-port region |
| issue_rdy | output | 1 | Decode accepts a token this cycle |
| stage_vld | output | 5 | Per-stage valid, bit 0 decode to bit 4 write-back |
| stage_tag | output | 5*TAG_W | Per-stage tags, stage i at bits i*TAG_W upward |
| stall | output | 1 | Front three stages frozen this cycle |
| bubble | output | 1 | Execute holds an inserted empty slot |
| cycle_cnt | output | CNT_W | Cycles since reset |
| stall_cnt | output | CNT_W | Stall cycles since reset |

## Verification
The hardest case to reach is the one-cycle limit. It needs a two-port writer still in write-back while the held dual-read token sits in memory, so that the detection condition holds again in the cycle after a stall. The bench builds this by issuing two back-to-back two-port writers directly ahead of the dual-read token. Another sequence leaves the inserted empty slot in write-back while a second dual-read token occupies memory, to show that the slot never counts as a write.

// File: rtl/dualrd_stall_pkg.sv
package dualrd_stall_pkg;

    localparam int TAG_W   = 4;
    localparam int N_STAGE = 5;
    localparam int IDX_DEC = 0;
    localparam int IDX_MEM = 2;
    localparam int IDX_EXE = 3;
    localparam int IDX_WB  = 4;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [1:0]       nrd;
        logic             rd0_dp;
        logic             rd1_dp;
        logic             wb_en;
        logic             wb_dp;
    } tok_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/pipe_slot.sv
module pipe_slot
    import dualrd_stall_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic kill,
    input  tok_t d,
    output tok_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hold) begin
            q <= q;
        end else if (kill) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bw_conflict_detect.sv
module bw_conflict_detect (
    input  logic       m_vld,
    input  logic [1:0] m_nrd,
    input  logic       m_rd0_dp,
    input  logic       m_rd1_dp,
    input  logic       w_vld,
    input  logic       w_wb_en,
    input  logic       w_wb_dp,
    output logic       hit
);

    logic dual_dp_reads;
    logic dp_write;

    always_comb begin
        dual_dp_reads = m_vld && (m_nrd == 2'd2) && m_rd0_dp && m_rd1_dp;
        dp_write      = w_vld && w_wb_en && w_wb_dp;
        hit           = dual_dp_reads && dp_write;
    end

endmodule

// File: rtl/stall_fsm.sv
module stall_fsm
    import dualrd_stall_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic stall,
    output logic bubble
);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        bubble  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall = hit;
                if (hit) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                bubble  = 1'b1;
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/perf_counters.sv
module perf_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic [CNT_W-1:0] stall_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_cnt <= '0;
            stall_cnt <= '0;
        end else begin
            cycle_cnt <= cycle_cnt + 1'b1;
            if (stall) begin
                stall_cnt <= stall_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dualrd_stall_top.sv
module dualrd_stall_top
    import dualrd_stall_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [1:0]               in_nrd,
    input  logic                     in_rd0_dp,
    input  logic                     in_rd1_dp,
    input  logic                     in_wb_en,
    input  logic                     in_wb_dp,
    output logic                     issue_rdy,
    output logic [N_STAGE-1:0]       stage_vld,
    output logic [N_STAGE*TAG_W-1:0] stage_tag,
    output logic                     stall,
    output logic                     bubble,
    output logic [CNT_W-1:0]         cycle_cnt,
    output logic [CNT_W-1:0]         stall_cnt
);

    tok_t in_tok;
    tok_t stg_d [N_STAGE];
    tok_t stg_q [N_STAGE];
    tok_t mem_tok;
    tok_t wb_tok;
    logic hit;

    always_comb begin
        in_tok.vld    = in_vld;
        in_tok.tag    = in_tag;
        in_tok.nrd    = in_nrd;
        in_tok.rd0_dp = in_rd0_dp;
        in_tok.rd1_dp = in_rd1_dp;
        in_tok.wb_en  = in_wb_en;
        in_tok.wb_dp  = in_wb_dp;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_STAGE; gi++) begin : g_stage
            localparam bit IS_FRONT = (gi <= IDX_MEM);
            localparam bit IS_EXE   = (gi == IDX_EXE);
            logic hold_s;
            logic kill_s;

            if (gi == IDX_DEC) begin : g_src_in
                assign stg_d[gi] = in_tok;
            end else begin : g_src_prev
                assign stg_d[gi] = stg_q[gi-1];
            end

            assign hold_s = IS_FRONT ? stall : 1'b0;
            assign kill_s = IS_EXE ? stall : 1'b0;

            pipe_slot u_slot (
                .clk  (clk),
                .rst  (rst),
                .hold (hold_s),
                .kill (kill_s),
                .d    (stg_d[gi]),
                .q    (stg_q[gi])
            );

            assign stage_vld[gi]                = stg_q[gi].vld;
            assign stage_tag[gi*TAG_W +: TAG_W] = stg_q[gi].tag;
        end
    endgenerate

    assign mem_tok = stg_q[IDX_MEM];
    assign wb_tok  = stg_q[IDX_WB];

    bw_conflict_detect u_detect (
        .m_vld    (mem_tok.vld),
        .m_nrd    (mem_tok.nrd),
        .m_rd0_dp (mem_tok.rd0_dp),
        .m_rd1_dp (mem_tok.rd1_dp),
        .w_vld    (wb_tok.vld),
        .w_wb_en  (wb_tok.wb_en),
        .w_wb_dp  (wb_tok.wb_dp),
        .hit      (hit)
    );

    stall_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .stall  (stall),
        .bubble (bubble)
    );

    perf_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .cycle_cnt (cycle_cnt),
        .stall_cnt (stall_cnt)
    );

    assign issue_rdy = !stall;

endmodule

// File: rtl/dualrd_stall_chk.sv
module dualrd_stall_chk
    import dualrd_stall_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_STAGE-1:0]       stage_vld,
    input logic [N_STAGE*TAG_W-1:0] stage_tag,
    input logic                     stall,
    input logic                     bubble,
    input logic [CNT_W-1:0]         cycle_cnt,
    input logic [CNT_W-1:0]         stall_cnt,
    input logic                     m_vld,
    input logic [1:0]               m_nrd,
    input logic                     m_rd0_dp,
    input logic                     m_rd1_dp,
    input logic                     w_vld,
    input logic                     w_wb_en,
    input logic                     w_wb_dp
);

    localparam int FRONT_W = (IDX_MEM + 1) * TAG_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (stage_vld == '0 && !stall && !bubble && cycle_cnt == '0 && stall_cnt == '0));

    assert_stall_cause_R3: assert property (@(posedge clk) disable iff (rst)
        stall |-> (m_vld && m_nrd == 2'd2 && m_rd0_dp && m_rd1_dp && w_vld && w_wb_en && w_wb_dp));

    assert_front_hold_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> (stage_tag[FRONT_W-1:0] == $past(stage_tag[FRONT_W-1:0]) && !stage_vld[IDX_EXE]));

    assert_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    assert_bubble_follow_R12: assert property (@(posedge clk) disable iff (rst)
        stall |=> bubble);

    assert_cycle_step_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1));

endmodule

bind dualrd_stall_top dualrd_stall_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stage_vld (stage_vld),
    .stage_tag (stage_tag),
    .stall     (stall),
    .bubble    (bubble),
    .cycle_cnt (cycle_cnt),
    .stall_cnt (stall_cnt),
    .m_vld     (mem_tok.vld),
    .m_nrd     (mem_tok.nrd),
    .m_rd0_dp  (mem_tok.rd0_dp),
    .m_rd1_dp  (mem_tok.rd1_dp),
    .w_vld     (wb_tok.vld),
    .w_wb_en   (wb_tok.wb_en),
    .w_wb_dp   (wb_tok.wb_dp)
);

// File: tb/dualrd_stall_tb.sv
module dualrd_stall_top_tb_top;
    import dualrd_stall_pkg::*;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [1:0] in_nrd = '0;
    logic in_rd0_dp = 1'b0;
    logic in_rd1_dp = 1'b0;
    logic in_wb_en = 1'b0;
    logic in_wb_dp = 1'b0;
    logic issue_rdy;
    logic [N_STAGE-1:0] stage_vld;
    logic [N_STAGE*TAG_W-1:0] stage_tag;
    logic stall;
    logic bubble;
    logic [CNT_W-1:0] cycle_cnt;
    logic [CNT_W-1:0] stall_cnt;

    int checks = 0;
    int fails = 0;
    int exp_stalls = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dualrd_stall_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_tag(in_tag), .in_nrd(in_nrd),
        .in_rd0_dp(in_rd0_dp), .in_rd1_dp(in_rd1_dp), .in_wb_en(in_wb_en),
        .in_wb_dp(in_wb_dp), .issue_rdy(issue_rdy), .stage_vld(stage_vld),
        .stage_tag(stage_tag), .stall(stall), .bubble(bubble),
        .cycle_cnt(cycle_cnt), .stall_cnt(stall_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tag_of(input int s);
        return int'(stage_tag[s*TAG_W +: TAG_W]);
    endfunction

    // Present a token for one edge, then return at the next falling edge.
    task automatic push(input bit v, input int tag, input int nrd,
                        input bit r0, input bit r1, input bit we, input bit wd);
        in_vld = v; in_tag = TAG_W'(tag); in_nrd = 2'(nrd);
        in_rd0_dp = r0; in_rd1_dp = r1; in_wb_en = we; in_wb_dp = wd;
        @(negedge clk);
    endtask

    task automatic nop();
        push(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) nop();
    endtask

    task automatic t_reset();
        chk("R1 vld", int'(stage_vld), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 bubble", int'(bubble), 0);
        chk("R1 cycle_cnt", int'(cycle_cnt), 0);
        chk("R1 stall_cnt", int'(stall_cnt), 0);
        chk("R10 rdy", int'(issue_rdy), 1);
    endtask

    task automatic t_flow();
        push(1, 5, 1, 1, 0, 1, 1);
        for (int s = 0; s < N_STAGE; s++) begin
            chk("R2 vld", int'(stage_vld), 1 << s);
            chk("R2 tag", tag_of(s), 5);
            nop();
        end
        chk("R2 drained", int'(stage_vld), 0);
    endtask

    task automatic t_conflict();
        push(1, 1, 0, 0, 0, 1, 1);   // two-port writer
        push(1, 2, 0, 0, 0, 0, 0);   // filler
        push(1, 3, 2, 1, 1, 0, 0);   // dual two-port read
        nop();
        nop();
        chk("R3 stall", int'(stall), 1);
        chk("R10 rdy low", int'(issue_rdy), 0);
        exp_stalls++;
        push(1, 9, 0, 0, 0, 0, 0);   // offered during the stall
        chk("R6 mem held vld", int'(stage_vld[IDX_MEM]), 1);
        chk("R6 mem held tag", tag_of(IDX_MEM), 3);
        chk("R6 exe bubble", int'(stage_vld[IDX_EXE]), 0);
        chk("R6 wb retire vld", int'(stage_vld[IDX_WB]), 1);
        chk("R6 wb retire tag", tag_of(IDX_WB), 2);
        chk("R10 dec not captured", int'(stage_vld[IDX_DEC]), 0);
        chk("R12 bubble", int'(bubble), 1);
        chk("R11 stall_cnt", int'(stall_cnt), exp_stalls);
        nop();
        chk("R6 resume tag", tag_of(IDX_EXE), 3);
        chk("R6 resume vld", int'(stage_vld[IDX_EXE]), 1);
        chk("R10 no tag 9", int'(stage_vld[1:0]), 0);
        chk("R12 bubble clear", int'(bubble), 0);
        flush();
    endtask

    // Generic single-cycle no-stall check: writer, filler, reader.
    task automatic t_nostall(input string req, input bit we, input bit wd,
                             input int nrd, input bit r0, input bit r1);
        push(1, 4, 0, 0, 0, we, wd);
        push(1, 6, 0, 0, 0, 0, 0);
        push(1, 7, nrd, r0, r1, 0, 0);
        nop();
        nop();
        chk({req, " stall"}, int'(stall), 0);
        nop();
        chk({req, " exe tag"}, tag_of(IDX_EXE), 7);
        chk({req, " exe vld"}, int'(stage_vld[IDX_EXE]), 1);
        flush();
    endtask

    task automatic t_once();
        push(1, 1, 0, 0, 0, 1, 1);
        push(1, 2, 0, 0, 0, 1, 1);
        push(1, 3, 2, 1, 1, 0, 0);
        nop();
        nop();
        chk("R7 first stall", int'(stall), 1);
        exp_stalls++;
        nop();
        chk("R7 writer in wb", tag_of(IDX_WB), 2);
        chk("R7 no second stall", int'(stall), 0);
        nop();
        chk("R7 exe tag", tag_of(IDX_EXE), 3);
        flush();
    endtask

    task automatic t_bubble_wb();
        push(1, 1, 0, 0, 0, 1, 1);
        push(1, 2, 0, 0, 0, 0, 0);
        push(1, 3, 2, 1, 1, 0, 0);
        push(1, 8, 2, 1, 1, 0, 0);
        nop();
        chk("R8 stall", int'(stall), 1);
        exp_stalls++;
        nop();
        nop();
        chk("R8 wb empty", int'(stage_vld[IDX_WB]), 0);
        chk("R8 mem tag", tag_of(IDX_MEM), 8);
        chk("R8 no stall", int'(stall), 0);
        flush();
        chk("R11 stall_cnt total", int'(stall_cnt), exp_stalls);
    endtask

    task automatic t_cycles();
        int c0;
        c0 = int'(cycle_cnt);
        for (int i = 0; i < 4; i++) nop();
        chk("R11 cycle_cnt", int'(cycle_cnt), c0 + 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_flow();
        t_conflict();
        t_nostall("R4 rd1 sp", 1'b1, 1'b1, 2, 1'b1, 1'b0);
        t_nostall("R4 rd0 sp", 1'b1, 1'b1, 2, 1'b0, 1'b1);
        t_nostall("R5 wb sp", 1'b1, 1'b0, 2, 1'b1, 1'b1);
        t_nostall("R5 wb reg", 1'b0, 1'b1, 2, 1'b1, 1'b1);
        t_nostall("R9 one read", 1'b1, 1'b1, 1, 1'b1, 1'b1);
        t_once();
        t_bubble_wb();
        t_cycles();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule